// File: doc/BRIEF.md
# Windowed Binary Run-Length Encoder

This block walks a stored binary picture row by row inside a rectangular window set by the host. Every pixel is read as 1 for foreground and 0 for background. The block turns each row of the window into a list of foreground runs, adds up the foreground pixels it visits, and writes everything as 16-bit words into a shared memory built from two byte-wide banks. The host reads the results from that memory.

A start pulse samples the window bounds. The block first clears a picture-complete flag word and then scans. Each row ends with an end-of-line record, which the host can poll, and with a pulse on `line_done`. When the last window row is finished, the block writes the 32-bit foreground sum and then sets the flag word to 1. After that it is idle and will take the next picture. The host can therefore work on one result set while the image buffer is being refilled for the next.

Top module: `rle_window_encoder`

## Requirements
- R1: After reset `busy` and `mem_we` are 0. A `start` pulse taken while idle makes `busy` 1 on the next cycle. The first memory write of a picture puts 16'h0000 at flag address `FLAG_ADDR`.
- R2: Pixels are requested (`pix_rd` = 1) only at columns from `win_xmin` to `win_xmax` and rows from `win_ymin` to `win_ymax`, all bounds inclusive. Foreground outside the window has no effect on any write.
- R3: Each foreground run is written as three consecutive words in this order: row, first column, last column. Records are stored at consecutive even byte addresses starting at `REC_BASE`.
- R4: A run that is still open at column `win_xmax` is closed there, and its last column is `win_xmax`. This includes a run of one pixel at `win_xmax`.
- R5: After the runs of every window row the block writes an end-of-line record of three words: 16'hFFFF, then the row, then the number of runs in that row. `line_done` pulses during the write of the third word.
- R6: A window with no foreground pixels produces only end-of-line records, each with a run count of 0, and a sum of 0.
- R7: After the last end-of-line record the block writes the foreground sum, low word first and then high word. It then writes 16'h0001 to `FLAG_ADDR` with `pic_done` high in that same cycle. After that `busy` returns to 0.
- R8: A `start` pulse while `busy` is 1 is ignored. The picture in progress completes with the window it started with.
- R9: Every write drives `mem_be` = 2'b11 and uses an even byte address.
- R10: Each new picture starts from a sum of 0 and puts its records at `REC_BASE` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a picture (taken only while idle) |
| win_xmin | input | 10 | Left window column, inclusive |
| win_xmax | input | 10 | Right window column, inclusive |
| win_ymin | input | 10 | Top window row, inclusive |
| win_ymax | input | 10 | Bottom window row, inclusive |
| pix_rd | output | 1 | Pixel request valid |
| pix_row | output | 10 | Requested pixel row |
| pix_col | output | 10 | Requested pixel column |
| pix_bit | input | 1 | Pixel value for the request in the same cycle |
| mem_we | output | 1 | Shared-memory word write |
| mem_be | output | 2 | Byte-bank enables |
| mem_addr | output | 15 | Byte address of the word written |
| mem_wdata | output | 16 | Word written |
| line_done | output | 1 | Pulse as a row's end-of-line record completes |
| pic_done | output | 1 | Pulse with the flag-set write |
| busy | output | 1 | Picture in progress |

## Verification
The hardest case to reach is a run that starts earlier in a row and is still open at the right window edge. In that case one pixel closes the run and also triggers the end-of-line record, so two records are emitted back to back. The stimulus reaches it with a fully lit window, with a single lit pixel at the right-edge column, and with a window one column wide. Random pictures with edge pixels set to 1 add more cases of the same kind. A second hard case is a start pulse that arrives in the middle of a scan with a different window. The bench gives that pulse while the block is busy and checks that the stored output still matches the first window.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int CW  = 10;   // column width
    localparam int RW  = 10;   // row width
    localparam int AW  = 15;   // byte address width (two 16K banks)
    localparam int DW  = 16;   // shared-memory word width
    localparam int SW  = 32;   // foreground sum width
    localparam int NW  = 16;   // per-row run count width

    typedef enum logic [2:0] {
        ST_IDLE, ST_CLR, ST_SCAN, ST_RUN, ST_EOL, ST_SUMLO, ST_SUMHI, ST_SET
    } st_e;

    typedef struct packed {
        st_e            st;
        logic [RW-1:0]  row;
        logic [CW-1:0]  col;
        logic [CW-1:0]  xmin;
        logic [CW-1:0]  xmax;
        logic [RW-1:0]  ymax;
        logic           in_run;
        logic [CW-1:0]  rstart;
        logic [CW-1:0]  rs;
        logic [CW-1:0]  re;
        logic           eol_pend;
        logic [1:0]     idx;
        logic [AW-1:0]  wptr;
        logic [SW-1:0]  sum;
        logic [NW-1:0]  nruns;
    } ctl_t;
endpackage

// File: rtl/rle_scan_ctrl.sv
module rle_scan_ctrl
    import rle_pkg::*;
#(
    parameter logic [AW-1:0] REC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] win_xmin,
    input  logic [CW-1:0] win_xmax,
    input  logic [RW-1:0] win_ymin,
    input  logic [RW-1:0] win_ymax,
    input  logic          pix_bit,
    output ctl_t          ctl
);
    ctl_t c_d, c_q;

    always_comb begin
        logic last;
        logic rec;
        c_d  = c_q;
        last = (c_q.col == c_q.xmax);
        rec  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.xmin   = win_xmin;
                    c_d.xmax   = win_xmax;
                    c_d.ymax   = win_ymax;
                    c_d.row    = win_ymin;
                    c_d.col    = win_xmin;
                    c_d.sum    = '0;
                    c_d.nruns  = '0;
                    c_d.in_run = 1'b0;
                    c_d.idx    = '0;
                    c_d.wptr   = REC_BASE;
                    c_d.st     = ST_CLR;
                end
            end
            ST_CLR: c_d.st = ST_SCAN;
            ST_SCAN: begin
                if (pix_bit) begin
                    c_d.sum = c_q.sum + 1'b1;
                    if (!c_q.in_run) begin
                        c_d.rstart = c_q.col;
                        c_d.in_run = 1'b1;
                    end
                    if (last) begin
                        c_d.rs     = c_q.in_run ? c_q.rstart : c_q.col;
                        c_d.re     = c_q.col;
                        c_d.in_run = 1'b0;
                        rec        = 1'b1;
                    end
                end else if (c_q.in_run) begin
                    c_d.rs     = c_q.rstart;
                    c_d.re     = c_q.col - 1'b1;
                    c_d.in_run = 1'b0;
                    rec        = 1'b1;
                end
                c_d.col = c_q.col + 1'b1;
                c_d.idx = '0;
                if (rec) begin
                    c_d.st       = ST_RUN;
                    c_d.eol_pend = last;
                    c_d.nruns    = c_q.nruns + 1'b1;
                end else if (last) begin
                    c_d.st = ST_EOL;
                end
            end
            ST_RUN: begin
                c_d.wptr = c_q.wptr + 2'd2;
                c_d.idx  = c_q.idx + 1'b1;
                if (c_q.idx == 2'd2) begin
                    c_d.idx = '0;
                    c_d.st  = c_q.eol_pend ? ST_EOL : ST_SCAN;
                end
            end
            ST_EOL: begin
                c_d.wptr = c_q.wptr + 2'd2;
                c_d.idx  = c_q.idx + 1'b1;
                if (c_q.idx == 2'd2) begin
                    c_d.idx    = '0;
                    c_d.nruns  = '0;
                    c_d.in_run = 1'b0;
                    if (c_q.row == c_q.ymax) begin
                        c_d.st = ST_SUMLO;
                    end else begin
                        c_d.row = c_q.row + 1'b1;
                        c_d.col = c_q.xmin;
                        c_d.st  = ST_SCAN;
                    end
                end
            end
            ST_SUMLO: begin
                c_d.wptr = c_q.wptr + 2'd2;
                c_d.st   = ST_SUMHI;
            end
            ST_SUMHI: c_d.st = ST_SET;
            ST_SET:   c_d.st = ST_IDLE;
            default:  c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign ctl = c_q;
endmodule

// File: rtl/rle_word_fmt.sv
module rle_word_fmt
    import rle_pkg::*;
#(
    parameter logic [AW-1:0] FLAG_ADDR = '1
) (
    input  ctl_t          ctl,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          line_end,
    output logic          pic_end
);
    logic [DW-1:0] row_w;
    assign row_w = DW'(ctl.row);

    always_comb begin
        we    = 1'b1;
        addr  = ctl.wptr;
        wdata = '0;
        unique case (ctl.st)
            ST_CLR: begin addr = FLAG_ADDR; wdata = '0; end
            ST_SET: begin addr = FLAG_ADDR; wdata = DW'(1); end
            ST_RUN: begin
                unique case (ctl.idx)
                    2'd0:    wdata = row_w;
                    2'd1:    wdata = DW'(ctl.rs);
                    default: wdata = DW'(ctl.re);
                endcase
            end
            ST_EOL: begin
                unique case (ctl.idx)
                    2'd0:    wdata = '1;
                    2'd1:    wdata = row_w;
                    default: wdata = DW'(ctl.nruns);
                endcase
            end
            ST_SUMLO: wdata = ctl.sum[DW-1:0];
            ST_SUMHI: wdata = ctl.sum[SW-1:DW];
            default:  we = 1'b0;
        endcase
    end

    assign line_end = (ctl.st == ST_EOL) && (ctl.idx == 2'd2);
    assign pic_end  = (ctl.st == ST_SET);
endmodule

// File: rtl/rle_window_encoder.sv
module rle_window_encoder
    import rle_pkg::*;
#(
    parameter logic [AW-1:0] REC_BASE  = '0,
    parameter logic [AW-1:0] FLAG_ADDR = 15'h7FFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] win_xmin,
    input  logic [CW-1:0] win_xmax,
    input  logic [RW-1:0] win_ymin,
    input  logic [RW-1:0] win_ymax,
    output logic          pix_rd,
    output logic [RW-1:0] pix_row,
    output logic [CW-1:0] pix_col,
    input  logic          pix_bit,
    output logic          mem_we,
    output logic [1:0]    mem_be,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          line_done,
    output logic          pic_done,
    output logic          busy
);
    ctl_t ctl;

    rle_scan_ctrl #(.REC_BASE(REC_BASE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .win_xmin (win_xmin),
        .win_xmax (win_xmax),
        .win_ymin (win_ymin),
        .win_ymax (win_ymax),
        .pix_bit  (pix_bit),
        .ctl      (ctl)
    );

    rle_word_fmt #(.FLAG_ADDR(FLAG_ADDR)) u_fmt (
        .ctl      (ctl),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .line_end (line_done),
        .pic_end  (pic_done)
    );

    assign mem_be  = mem_we ? 2'b11 : 2'b00;
    assign pix_rd  = (ctl.st == ST_SCAN);
    assign pix_row = ctl.row;
    assign pix_col = ctl.col;
    assign busy    = (ctl.st != ST_IDLE);
endmodule

// File: rtl/rle_window_encoder_chk.sv
module rle_window_encoder_chk
    import rle_pkg::*;
#(
    parameter logic [AW-1:0] FLAG_ADDR = 15'h7FFE
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_we,
    input logic [1:0]    mem_be,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          line_done,
    input logic          pic_done,
    input logic          busy
);
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_flag_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_we && mem_addr == FLAG_ADDR && mem_wdata == '0));

    p_line_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> mem_we);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pic_done |-> (mem_we && mem_addr == FLAG_ADDR && mem_wdata == DW'(1)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pic_done |=> !busy);

    p_word_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 2'b11 && !mem_addr[0]));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
endmodule

bind rle_window_encoder rle_window_encoder_chk #(.FLAG_ADDR(FLAG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .line_done (line_done),
    .pic_done  (pic_done),
    .busy      (busy)
);

// File: tb/rle_window_encoder_bench.sv
module rle_window_encoder_bench;
    localparam int CLK_P = 10;
    localparam int IMG   = 64;
    localparam logic [14:0] FLAG = 15'h7FFE;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  win_xmin = '0, win_xmax = '0, win_ymin = '0, win_ymax = '0;
    logic        pix_rd;
    logic [9:0]  pix_row, pix_col;
    logic        pix_bit;
    logic        mem_we;
    logic [1:0]  mem_be;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        line_done, pic_done, busy;

    bit img [IMG][IMG];

    int checks = 0, errors = 0, cycles = 0;
    int out_of_win = 0, bad_writes = 0, lines_seen = 0, done_ok = 0;
    int wx0, wx1, wy0, wy1;
    logic [14:0] cap_a[$], exp_a[$];
    logic [15:0] cap_d[$], exp_d[$];

    always #(CLK_P/2) clk = ~clk;

    assign pix_bit = (pix_row < IMG && pix_col < IMG) ? img[pix_row][pix_col] : 1'b0;

    rle_window_encoder u_rle_window_encoder (
        .clk(clk), .rst_n(rst_n), .start(start),
        .win_xmin(win_xmin), .win_xmax(win_xmax), .win_ymin(win_ymin), .win_ymax(win_ymax),
        .pix_rd(pix_rd), .pix_row(pix_row), .pix_col(pix_col), .pix_bit(pix_bit),
        .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .line_done(line_done), .pic_done(pic_done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (pix_rd && (pix_col < wx0 || pix_col > wx1 || pix_row < wy0 || pix_row > wy1))
                out_of_win++;
            if (mem_we) begin
                cap_a.push_back(mem_addr);
                cap_d.push_back(mem_wdata);
                if (mem_be != 2'b11 || mem_addr[0]) bad_writes++;
                if (pic_done && mem_addr == FLAG && mem_wdata == 16'h1) done_ok++;
            end
            if (line_done) lines_seen++;
        end
    end

    task automatic push_w(input logic [15:0] d);
        exp_a.push_back(15'(2 * (exp_d.size() - 1)));
        exp_d.push_back(d);
    endtask

    // Expected stream: flag clear, run and end-of-line records, sum, flag set.
    task automatic build_expected();
        int sum = 0;
        exp_a.delete(); exp_d.delete();
        exp_a.push_back(FLAG); exp_d.push_back(16'h0);
        for (int r = wy0; r <= wy1; r++) begin
            int n = 0;
            int s = -1;
            for (int c = wx0; c <= wx1; c++) begin
                bit b = (r < IMG && c < IMG) ? img[r][c] : 1'b0;
                if (b) begin
                    sum++;
                    if (s < 0) s = c;
                end
                if (s >= 0 && (!b || c == wx1)) begin
                    push_w(16'(r)); push_w(16'(s)); push_w(16'(b ? c : c - 1));
                    n++; s = -1;
                end
            end
            push_w(16'hFFFF); push_w(16'(r)); push_w(16'(n));
        end
        push_w(16'(sum)); push_w(16'(sum >>> 16));
        exp_a.push_back(FLAG); exp_d.push_back(16'h1);
    endtask

    task automatic run_picture(input string req, input bit mid_start);
        int idx = -1;
        cap_a.delete(); cap_d.delete();
        lines_seen = 0; done_ok = 0; out_of_win = 0;
        build_expected();
        @(negedge clk);
        win_xmin = 10'(wx0); win_xmax = 10'(wx1); win_ymin = 10'(wy0); win_ymax = 10'(wy1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1", "busy after start", busy, 1);
        if (mid_start) begin
            repeat (7) @(negedge clk);
            win_xmin = 10'd0; win_xmax = 10'd63; win_ymin = 10'd0; win_ymax = 10'd63;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy && cycles < WD_LIMIT) @(negedge clk);
        check(cap_a.size() == exp_a.size(), req, "write count", cap_a.size(), exp_a.size());
        for (int i = 0; i < exp_a.size() && i < cap_a.size(); i++)
            if (idx < 0 && (cap_a[i] != exp_a[i] || cap_d[i] != exp_d[i])) idx = i;
        if (idx >= 0)
            check(1'b0, req, $sformatf("word %0d addr/data", idx),
                  {cap_a[idx], cap_d[idx]}, {exp_a[idx], exp_d[idx]});
        else
            check(1'b1, req, "stream", 0, 0);
        check(lines_seen == wy1 - wy0 + 1, "R5", "line_done pulses", lines_seen, wy1 - wy0 + 1);
        check(done_ok == 1, "R7", "pic_done with flag write", done_ok, 1);
        check(out_of_win == 0, "R2", "reads outside window", out_of_win, 0);
        check(busy == 1'b0, "R7", "idle after picture", busy, 0);
    endtask

    task automatic fill(input int pct);
        for (int r = 0; r < IMG; r++)
            for (int c = 0; c < IMG; c++)
                img[r][c] = (($urandom % 100) < pct);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && mem_we == 1'b0, "R1", "idle after reset", {busy, mem_we}, 0);

        // R4: fully lit window, every run closed at the right edge
        fill(100);
        wx0 = 5; wx1 = 20; wy0 = 2; wy1 = 6;
        run_picture("R4", 1'b0);

        // R4: single lit pixel at the right edge column
        fill(0); img[10][30] = 1'b1;
        wx0 = 12; wx1 = 30; wy0 = 9; wy1 = 11;
        run_picture("R4", 1'b0);

        // R4: window one column wide
        fill(50);
        wx0 = 17; wx1 = 17; wy0 = 0; wy1 = 20;
        run_picture("R4", 1'b0);

        // R6: empty window, foreground only outside (R2)
        fill(100);
        for (int r = 20; r <= 25; r++)
            for (int c = 30; c <= 40; c++) img[r][c] = 1'b0;
        wx0 = 30; wx1 = 40; wy0 = 20; wy1 = 25;
        run_picture("R6", 1'b0);

        // R8: start pulse mid-scan with another window
        fill(40);
        wx0 = 3; wx1 = 25; wy0 = 4; wy1 = 9;
        run_picture("R8", 1'b1);

        // R3 / R10: random windows and densities, pictures back to back
        for (int k = 0; k < 8; k++) begin
            fill(int'($urandom % 80) + 10);
            wx0 = $urandom % IMG; wx1 = wx0 + ($urandom % (IMG - wx0));
            wy0 = $urandom % IMG; wy1 = wy0 + ($urandom % (IMG - wy0));
            if (k % 2 == 0) begin
                wy1 = (wy1 - wy0 > 12) ? wy0 + 12 : wy1;
                for (int r = wy0; r <= wy1; r++) img[r][wx1] = 1'b1;
            end
            run_picture(k == 0 ? "R3" : "R10", 1'b0);
        end

        check(bad_writes == 0, "R9", "non-word writes", bad_writes, 0);
        if (cycles >= WD_LIMIT) check(1'b0, "R1", "watchdog expired", cycles, WD_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * (WD_LIMIT + 1000));
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule